// File: doc/BRIEF.md
# Gated PCI Interrupt Mapping Controller

This block sits between the interrupt request lines of a PCI host and the interrupt controller that receives them. It takes 32 level-sensitive request lines, organised as eight groups of four, and passes each group to its outputs only while that group's enable bit is set. A disabled group drives its four outputs low whatever its inputs do. The output stage is registered, so each output changes one clock after the input level or the enable that governs it.

Software controls the eight enable bits through a 32-bit register bus. The registers sit in a 64-byte window of eight doubleword slots, one slot per group. Only the upper word of each slot holds a register. The lower word reads as zero and ignores writes. In each register only the top bit can be written. The lower 31 bits read back a fixed pattern that carries the group number.

A separate combinational path turns a device/function number and an INTx pin index into the line number the request arrives on. It serves either a primary-bus device or a device behind a secondary bridge, and each of those uses its own mapping.

Top module: `irq_map_ctrl`

## Requirements
- R1: After any assertion of `rst_ni` all eight enable bits are 0, and `irq_o` is 0 while reset is held and afterwards until an enable is set.
- R2: A read of the upper word of slot k (offset 0xC00 + 8k + 4, k = 0..7) returns bit 31 = enable k and bits 30:0 = 0x7C0 | (k << 2).
- R3: A write to the upper word of slot k copies write-data bit 31 into enable k. Bits 30:0 of that register stay at their fixed pattern whatever data is written.
- R4: A read of the lower word of any slot (offset bit 2 clear) returns 0. A write there changes no enable bit.
- R5: An access outside offsets 0xC00 to 0xC3F reads as 0 and changes no enable bit. Offset bits 1:0 are not decoded inside the window.
- R6: While enable g is set, `irq_o[4g+j]` equals `irq_lines_i[4g+j]` as sampled at the previous clock edge.
- R7: While enable g is clear, `irq_o[4g+3:4g]` is 0 whatever the input levels.
- R8: A change of an enable bit reaches `irq_o` at the clock edge after the edge that stored the enable. A change of an input level reaches `irq_o` at the next clock edge.
- R9: With `bus_sel_i` = 0 (primary bus), `line_num_o` = 16 * devfn[0] + pin.
- R10: With `bus_sel_i` = 1 (secondary bridge), `line_num_o` = 4 * devfn[4:3] + pin, which gives each slot its own group of four.
- R11: `reg_rdata_o` is loaded at the clock edge that samples a read request (`reg_req_i` = 1, `reg_we_i` = 0). It holds its value across idle cycles and across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 16 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data; only bit 31 is used |
| reg_rdata_o | output | 32 | Read data, registered |
| irq_lines_i | input | 32 | Level-sensitive request lines, group g on bits 4g+3:4g |
| irq_o | output | 32 | Gated, registered interrupt outputs |
| devfn_i | input | 8 | Device/function number for line conversion |
| intx_pin_i | input | 2 | INTx pin index 0..3 (INTA..INTD) |
| bus_sel_i | input | 1 | 0 = primary-bus mapping, 1 = secondary-bridge mapping |
| line_num_o | output | 5 | Converted line number |

## Verification
The assertions assume that `rst_ni` is held low from time zero through at least one clock edge. They also assume that register inputs are stable around each rising edge, since a request is taken to be sampled in exactly one cycle. The bench keeps to both. It drives every input at the falling edge, holds each request for one full cycle, and starts with reset already asserted. The window base is aligned to its size, which the checker's slot-index arithmetic needs, and the stimulus includes off-window offsets whose low bits alias a live slot. Those offsets show that such aliasing stays harmless.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned SLOT_BYTES = 8;
  localparam int unsigned PIN_W      = 2;

  typedef enum logic {
    BUS_PRIMARY   = 1'b0,
    BUS_SECONDARY = 1'b1
  } bus_kind_e;

  // Read-only low field of the mapping register for group k
  function automatic logic [REG_W-2:0] map_fixed_field(int unsigned k);
    logic [REG_W-1:0] v;
    v = 32'h0000_07C0 | (32'(k) << 2);
    return v[REG_W-2:0];
  endfunction

endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_map_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned WIN_BASE   = 32'h0000_0C00
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wbit_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic [NUM_GROUPS-1:0] en_o
);

  localparam int unsigned WIN_BYTES = NUM_GROUPS * SLOT_BYTES;
  localparam int unsigned IDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int unsigned IDX_LSB   = $clog2(SLOT_BYTES);

  logic              in_win, live;
  logic [IDX_W-1:0]  idx;
  logic [REG_W-1:0]  rd_d, rd_q;
  logic [NUM_GROUPS-1:0] en_q;

  assign in_win = ({{(32-ADDR_W){1'b0}}, addr_i} >= WIN_BASE) &&
                  ({{(32-ADDR_W){1'b0}}, addr_i} <  WIN_BASE + WIN_BYTES);
  assign idx    = addr_i[IDX_LSB +: IDX_W];
  // only the upper word of each slot is a register
  assign live   = in_win && addr_i[2];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      en_q[g] <= 1'b0;
      else if (req_i && we_i && live && (idx == IDX_W'(g))) en_q[g] <= wbit_i;
    end
  end

  always_comb begin
    rd_d = '0;
    for (int k = 0; k < NUM_GROUPS; k++) begin
      if (live && (idx == IDX_W'(k))) rd_d = {en_q[k], map_fixed_field(k)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rd_q <= '0;
    else if (req_i && !we_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
  assign en_o    = en_q;

endmodule

// File: rtl/irq_map_gate.sv
module irq_map_gate #(
  parameter int unsigned NUM_GROUPS      = 8,
  parameter int unsigned LINES_PER_GROUP = 4,
  localparam int unsigned NUM_LINES      = NUM_GROUPS * LINES_PER_GROUP
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_GROUPS-1:0] en_i,
  input  logic [NUM_LINES-1:0]  lines_i,
  output logic [NUM_LINES-1:0]  irq_o
);

  logic [LINES_PER_GROUP-1:0] grp_q [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      grp_q[g] <= '0;
      else if (en_i[g]) grp_q[g] <= lines_i[g*LINES_PER_GROUP +: LINES_PER_GROUP];
      else              grp_q[g] <= '0;
    end
    assign irq_o[g*LINES_PER_GROUP +: LINES_PER_GROUP] = grp_q[g];
  end

endmodule

// File: rtl/irq_line_calc.sv
module irq_line_calc
  import irq_map_pkg::*;
#(
  parameter int unsigned DEVFN_W = 8,
  parameter int unsigned LINE_W  = 5
) (
  input  logic [DEVFN_W-1:0] devfn_i,
  input  logic [PIN_W-1:0]   pin_i,
  input  bus_kind_e          kind_i,
  output logic [LINE_W-1:0]  line_o
);

  localparam int unsigned PRI_FN_STRIDE = 16;
  localparam int unsigned SLOT_STRIDE   = 4;

  logic [LINE_W-1:0] pri_line, sec_line;
  logic              unused_devfn;

  assign pri_line = (devfn_i[0] ? LINE_W'(PRI_FN_STRIDE) : '0) + LINE_W'(pin_i);
  assign sec_line = LINE_W'(devfn_i[4:3]) * LINE_W'(SLOT_STRIDE) + LINE_W'(pin_i);
  assign line_o   = (kind_i == BUS_SECONDARY) ? sec_line : pri_line;

  assign unused_devfn = ^{devfn_i[DEVFN_W-1:5], devfn_i[2:1]};

endmodule

// File: rtl/irq_map_ctrl.sv
module irq_map_ctrl
  import irq_map_pkg::*;
#(
  parameter int unsigned NUM_GROUPS      = 8,
  parameter int unsigned LINES_PER_GROUP = 4,
  parameter int unsigned ADDR_W          = 16,
  parameter int unsigned WIN_BASE        = 32'h0000_0C00,
  parameter int unsigned DEVFN_W         = 8,
  localparam int unsigned NUM_LINES      = NUM_GROUPS * LINES_PER_GROUP,
  localparam int unsigned LINE_W         = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  output logic [NUM_LINES-1:0] irq_o,
  input  logic [DEVFN_W-1:0]   devfn_i,
  input  logic [PIN_W-1:0]     intx_pin_i,
  input  logic                 bus_sel_i,
  output logic [LINE_W-1:0]    line_num_o
);

  logic [NUM_GROUPS-1:0] grp_en;
  logic                  unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-2:0];

  irq_map_regs #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W),
    .WIN_BASE   (WIN_BASE)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (reg_req_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wbit_i  (reg_wdata_i[REG_W-1]),
    .rdata_o (reg_rdata_o),
    .en_o    (grp_en)
  );

  irq_map_gate #(
    .NUM_GROUPS      (NUM_GROUPS),
    .LINES_PER_GROUP (LINES_PER_GROUP)
  ) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (grp_en),
    .lines_i (irq_lines_i),
    .irq_o   (irq_o)
  );

  irq_line_calc #(
    .DEVFN_W (DEVFN_W),
    .LINE_W  (LINE_W)
  ) u_line (
    .devfn_i (devfn_i),
    .pin_i   (intx_pin_i),
    .kind_i  (bus_kind_e'(bus_sel_i)),
    .line_o  (line_num_o)
  );

endmodule

// File: rtl/irq_map_chk.sv
module irq_map_chk #(
  parameter int unsigned NUM_GROUPS      = 8,
  parameter int unsigned LINES_PER_GROUP = 4,
  parameter int unsigned ADDR_W          = 16,
  parameter int unsigned WIN_BASE        = 32'h0000_0C00,
  parameter int unsigned LINE_W          = 5,
  localparam int unsigned NUM_LINES      = NUM_GROUPS * LINES_PER_GROUP,
  localparam int unsigned IDX_W          = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  wbit_i,
  input logic [31:0]           rdata_i,
  input logic [NUM_LINES-1:0]  lines_i,
  input logic [NUM_LINES-1:0]  irq_i,
  input logic [NUM_GROUPS-1:0] en_i,
  input logic [1:0]            pin_i,
  input logic                  bus_sel_i,
  input logic [LINE_W-1:0]     line_i
);

  logic             in_win, hit;
  logic [IDX_W-1:0] idx;
  logic             en_sel;

  assign in_win = ({{(32-ADDR_W){1'b0}}, addr_i} >= WIN_BASE) &&
                  ({{(32-ADDR_W){1'b0}}, addr_i} <  WIN_BASE + NUM_GROUPS * 8);
  assign idx    = addr_i[3 +: IDX_W];
  assign hit    = in_win && addr_i[2];
  assign en_sel = en_i[idx];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    assert_enabled_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(en_i[g]) |-> irq_i[g*LINES_PER_GROUP +: LINES_PER_GROUP] ==
                         $past(lines_i[g*LINES_PER_GROUP +: LINES_PER_GROUP]));
    assert_disabled_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(en_i[g]) |-> irq_i[g*LINES_PER_GROUP +: LINES_PER_GROUP] == '0);
  end

  assert_write_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && hit) |=> en_i[$past(idx)] == $past(wbit_i));

  assert_read_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && hit) |=> rdata_i[31] == $past(en_sel));

  assert_even_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !addr_i[2]) |=> $stable(en_i));

  assert_off_window_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !in_win) |=> rdata_i == '0);

  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_i));

  assert_pin_low_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_i[1:0] == pin_i);

  assert_secondary_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_sel_i |-> line_i < LINE_W'(16));

endmodule

bind irq_map_ctrl irq_map_chk #(
  .NUM_GROUPS      (NUM_GROUPS),
  .LINES_PER_GROUP (LINES_PER_GROUP),
  .ADDR_W          (ADDR_W),
  .WIN_BASE        (WIN_BASE),
  .LINE_W          (LINE_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (reg_req_i),
  .we_i      (reg_we_i),
  .addr_i    (reg_addr_i),
  .wbit_i    (reg_wdata_i[31]),
  .rdata_i   (reg_rdata_o),
  .lines_i   (irq_lines_i),
  .irq_i     (irq_o),
  .en_i      (grp_en),
  .pin_i     (intx_pin_i),
  .bus_sel_i (bus_sel_i),
  .line_i    (line_num_o)
);

// File: tb/tb_irq_map_ctrl.sv
`timescale 1ns/1ps
module tb_irq_map_ctrl;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [31:0] irq_lines_i = '0;
  logic [31:0] irq_o;
  logic [7:0]  devfn_i = '0;
  logic [1:0]  intx_pin_i = '0;
  logic        bus_sel_i = 1'b0;
  logic [4:0]  line_num_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_map_ctrl dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_req_i   (reg_req_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_lines_i (irq_lines_i),
    .irq_o       (irq_o),
    .devfn_i     (devfn_i),
    .intx_pin_i  (intx_pin_i),
    .bus_sel_i   (bus_sel_i),
    .line_num_o  (line_num_o)
  );

  function automatic logic [31:0] fixed_val(int k);
    return 32'h7C0 | (32'(k) << 2);
  endfunction

  function automatic logic [31:0] mask_of(logic [7:0] en);
    logic [31:0] m = '0;
    for (int g = 0; g < 8; g++) if (en[g]) m[g*4 +: 4] = 4'hF;
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic reg_read(logic [15:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
    @(negedge clk_i);
    reg_req_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic set_en(logic [7:0] en);
    for (int k = 0; k < 8; k++) reg_write(16'hC04 + 16'(k*8), {en[k], 31'h0});
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    irq_lines_i = '1;
    @(negedge clk_i);
    check("R1 irq after reset", irq_o, 32'h0);
    for (int k = 0; k < 8; k++) begin
      reg_read(16'hC04 + 16'(k*8), d);
      check("R2 reset readback", d, fixed_val(k));
    end
    irq_lines_i = '0;
  endtask

  task automatic t_write_bits();
    logic [31:0] d;
    reg_write(16'hC1C, 32'hFFFF_FFFF);
    reg_read(16'hC1C, d);
    check("R3 set enable only", d, 32'h8000_0000 | fixed_val(3));
    reg_write(16'hC1C, 32'h7FFF_FFFF);
    reg_read(16'hC1C, d);
    check("R3 clear enable only", d, fixed_val(3));
    reg_write(16'hC3D, 32'h8000_0000);
    reg_read(16'hC3C, d);
    check("R3 low address bits ignored", d, 32'h8000_0000 | fixed_val(7));
    reg_write(16'hC3C, 32'h0);
  endtask

  task automatic t_even_word();
    logic [31:0] d;
    reg_write(16'hC10, 32'hFFFF_FFFF);
    reg_read(16'hC14, d);
    check("R4 even write ignored", d, fixed_val(2));
    reg_write(16'hC14, 32'h8000_0000);
    reg_read(16'hC10, d);
    check("R4 even read zero", d, 32'h0);
    reg_write(16'hC10, 32'h0);
    reg_read(16'hC14, d);
    check("R4 even clear ignored", d, 32'h8000_0000 | fixed_val(2));
    reg_write(16'hC14, 32'h0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    reg_write(16'hC44, 32'h8000_0000);
    reg_write(16'h0404, 32'h8000_0000);
    reg_write(16'hBFC, 32'h8000_0000);
    reg_read(16'hC04, d);
    check("R5 alias write ignored", d, fixed_val(0));
    reg_read(16'hC3C, d);
    check("R5 below-window write ignored", d, fixed_val(7));
    reg_read(16'hC44, d);
    check("R5 off-window read", d, 32'h0);
    reg_read(16'h0404, d);
    check("R5 far read", d, 32'h0);
  endtask

  task automatic t_gating();
    logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_8765, 32'h0F0F_F0F0};
    logic [7:0]  ens  [3] = '{8'b0010_0001, 8'b1101_0110, 8'hFF};
    for (int e = 0; e < 3; e++) begin
      set_en(ens[e]);
      for (int p = 0; p < 4; p++) begin
        irq_lines_i = pats[p];
        @(negedge clk_i);
        check("R6 R7 gated output", irq_o, pats[p] & mask_of(ens[e]));
      end
    end
    set_en(8'h00);
    irq_lines_i = '1;
    @(negedge clk_i);
    check("R7 all disabled", irq_o, 32'h0);
  endtask

  task automatic t_timing();
    irq_lines_i = '1;
    @(negedge clk_i);
    reg_write(16'hC0C, 32'h8000_0000);
    check("R8 enable not yet visible", irq_o, 32'h0);
    @(negedge clk_i);
    check("R8 enable visible", irq_o, 32'h0000_00F0);
    irq_lines_i = 32'h0000_0050;
    #1;
    check("R8 input not yet visible", irq_o, 32'h0000_00F0);
    @(negedge clk_i);
    check("R8 input visible", irq_o, 32'h0000_0050);
    reg_write(16'hC0C, 32'h0);
    check("R8 disable not yet visible", irq_o, 32'h0000_0050);
    @(negedge clk_i);
    check("R8 disable visible", irq_o, 32'h0);
  endtask

  task automatic t_rdata_hold();
    logic [31:0] d;
    reg_write(16'hC04, 32'h8000_0000);
    reg_read(16'hC04, d);
    check("R11 read value", d, 32'h8000_0000 | fixed_val(0));
    reg_addr_i = 16'hC44;
    repeat (3) @(negedge clk_i);
    check("R11 hold idle", reg_rdata_o, 32'h8000_0000 | fixed_val(0));
    reg_write(16'hC04, 32'h0);
    check("R11 hold across write", reg_rdata_o, 32'h8000_0000 | fixed_val(0));
  endtask

  task automatic t_line_conv();
    int bad_p = 0, bad_s = 0;
    for (int f = 0; f < 256; f++) begin
      for (int p = 0; p < 4; p++) begin
        devfn_i = 8'(f); intx_pin_i = 2'(p);
        bus_sel_i = 1'b0; #1;
        checks++;
        if (line_num_o !== 5'((f % 2) * 16 + p)) begin
          errors++; bad_p++;
          if (bad_p < 4) $display("FAIL R9 devfn %0d pin %0d: actual %0d expected %0d",
                                  f, p, line_num_o, (f % 2) * 16 + p);
        end
        bus_sel_i = 1'b1; #1;
        checks++;
        if (line_num_o !== 5'(((f / 8) % 4) * 4 + p)) begin
          errors++; bad_s++;
          if (bad_s < 4) $display("FAIL R10 devfn %0d pin %0d: actual %0d expected %0d",
                                  f, p, line_num_o, ((f / 8) % 4) * 4 + p);
        end
      end
    end
    bus_sel_i = 1'b0;
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    set_en(8'hFF);
    irq_lines_i = '1;
    @(negedge clk_i);
    check("R1 pre-reset enabled", irq_o, 32'hFFFF_FFFF);
    rst_ni = 1'b0;
    #1;
    check("R1 irq cleared in reset", irq_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 irq after re-reset", irq_o, 32'h0);
    reg_read(16'hC2C, d);
    check("R1 enable cleared", d, fixed_val(5));
    irq_lines_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset_state();
    t_write_bits();
    t_even_word();
    t_window();
    t_gating();
    t_timing();
    t_rdata_hold();
    t_line_conv();
    t_reset_again();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule